// File: doc/BRIEF.md
# Spread-Spectrum Chip and Data-Bit Timing Generator

This block derives two strobes from a single reference clock for a direct-sequence spreading modulator. The chip strobe marks the start of each spreading-code chip. The data strobe marks the start of each data bit. The block keeps the index of the current chip, reads that chip from a small code store that is loaded through a parallel write port, and drives a modulated output. That output is the chip, inverted whenever the current data bit is 1. Both rates are produced as one-cycle enables in the reference clock domain, and no clock is gated.

A single mode input selects between two timing schemes. In the locked scheme the data-bit period is a power-of-two multiple of the code length. The chips advance either every reference cycle or every fourth cycle, so one bit can span several code periods, or one code period can carry several bits. In the free scheme the chips run at the reference rate and the data-bit period is an arbitrary 8-bit divisor of the reference clock. The code period then drifts relative to the bit edges. The configuration inputs take effect during reset, or at the end of the data bit in progress.

Top module: `ss_chip_timer`

## Requirements
- R1: While `rst` is high, `chip_en`, `data_en` and `mod_out` are 0, and the configuration inputs are captured. In the first cycle after `rst` falls, `chip_en` and `data_en` are both 1 and `chip_idx` is 0.
- R2: In free mode (`indep_mode`=1), or in locked mode with `dclk_cfg[2]`=0, `chip_en` is 1 in every cycle. In locked mode with `dclk_cfg[2]`=1, `chip_en` is 1 in cycles 0, 4, 8, … counted from the first cycle after reset or restart.
- R3: `chip_idx` advances by one in each cycle that follows a chip-strobe period, and it wraps from length−1 to 0.
- R4: In locked mode, `data_en` is 1 every L·2^n reference cycles, starting at cycle 0. Here L is the code length and n = `dclk_cfg[1:0]`. This holds for both settings of `dclk_cfg[2]`.
- R5: In free mode, `data_en` is 1 every D reference cycles, where D = `dclk_cfg`. A value of 0 means 256. `dclk_cfg[2]` then has no effect on the chip rate.
- R6: In locked mode with `dclk_cfg[2]`=0, every data strobe coincides with `chip_idx` 0. With `dclk_cfg[2]`=1 and L·2^n a multiple of 4, every data strobe coincides with a chip strobe. In free mode, `chip_idx` is not reset by data strobes.
- R7: `mod_out` = code[`chip_idx`] XOR b. Here b is `data_in` in a `data_en` cycle, and otherwise the value `data_in` had at the most recent data strobe. `data_in` is ignored outside data strobes.
- R8: A write with `code_we`=1 stores `code_wbit` at `code_waddr`. The new value is seen at `mod_out` from the next cycle. The code store is not cleared by reset.
- R9: Configuration inputs are sampled only in the last cycle of a data bit. If the sampled configuration differs from the active one, the next cycle restarts the sequence: `chip_idx` 0, `chip_en` 1 and `data_en` 1, all under the new settings.
- R10: A `code_len` below 2 acts as 2, and a value above 64 acts as 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| code_len | input | 7 | Spreading-code length, 2 to 64 |
| dclk_cfg | input | 8 | Rate setting: bit 2 selects the divide-by-4 chip rate, bits 1:0 are the power-of-two exponent, and all 8 bits form the free-mode divisor |
| indep_mode | input | 1 | 1 = free data rate, 0 = data rate locked to code periods |
| code_we | input | 1 | Code store write enable |
| code_waddr | input | 6 | Code store write address |
| code_wbit | input | 1 | Chip value to write |
| data_in | input | 1 | Serial data bit, used on data strobes |
| chip_en | output | 1 | One-cycle chip strobe |
| data_en | output | 1 | One-cycle data-bit strobe |
| chip_idx | output | 6 | Index of the current chip |
| mod_out | output | 1 | Spread output |

## Verification
Three events can fall in one cycle: the end of a data bit, a wrap of the chip index, and a configuration swap that restarts the sequence. The bench provokes this in two ways. It changes the configuration in the middle of a bit, in free mode where the old index would not be 0, and also in locked mode. It then checks that the bit runs to its full old length and that the following cycle shows index 0 with both strobes under the new period. The other coincidence is a data strobe landing on a chip strobe at the divide-by-4 rate. For this the bench sweeps code lengths and exponents, and compares every output each cycle against counts derived arithmetically from the cycle number.

// File: rtl/ss_timing_pkg.sv
package ss_timing_pkg;

    localparam int MAX_LEN = 64;
    localparam int IDX_W   = $clog2(MAX_LEN);
    localparam int LEN_W   = IDX_W + 1;
    localparam int DIV_W   = 8;
    localparam int PRE_W   = 2;
    localparam int CNT_W   = (LEN_W + 3 > DIV_W + 1) ? LEN_W + 3 : DIV_W + 1;

    typedef struct packed {
        logic [LEN_W-1:0] len;    // clamped code length
        logic             slow;   // chip every fourth reference cycle
        logic [1:0]       ratio;  // power-of-two exponent
        logic [DIV_W-1:0] div;    // free-mode divisor
        logic             indep;  // free data rate
    } ss_cfg_t;

    function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] l);
        if (l < LEN_W'(2))
            return LEN_W'(2);
        if (l > LEN_W'(MAX_LEN))
            return LEN_W'(MAX_LEN);
        return l;
    endfunction

    function automatic logic is_slow(input ss_cfg_t c);
        return c.slow & ~c.indep;
    endfunction

    // Data-bit period in reference cycles.
    function automatic logic [CNT_W-1:0] period_of(input ss_cfg_t c);
        if (c.indep)
            return (c.div == '0) ? CNT_W'(1 << DIV_W) : CNT_W'(c.div);
        return CNT_W'(c.len) << c.ratio;
    endfunction

endpackage

// File: rtl/ss_rate_gen.sv
module ss_rate_gen
    import ss_timing_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  ss_cfg_t cfg_in,
    output ss_cfg_t cfg_act,
    output logic    chip_en,
    output logic    data_en,
    output logic    chip_next,
    output logic    restart
);

    typedef struct packed {
        ss_cfg_t          cfg;
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] dcnt;
    } rg_state_t;

    rg_state_t        s_q, s_d;
    logic [CNT_W-1:0] per;
    logic             last;
    logic             restart_d;

    always_comb begin
        per       = period_of(s_q.cfg);
        last      = (s_q.dcnt == per - CNT_W'(1));
        s_d       = s_q;
        restart_d = 1'b0;
        if (rst) begin
            s_d.cfg  = cfg_in;
            s_d.pre  = '0;
            s_d.dcnt = '0;
        end else begin
            s_d.pre  = is_slow(s_q.cfg) ? s_q.pre + PRE_W'(1) : '0;
            s_d.dcnt = last ? '0 : s_q.dcnt + CNT_W'(1);
            if (last) begin
                s_d.cfg = cfg_in;
                if (cfg_in != s_q.cfg) begin
                    restart_d = 1'b1;
                    s_d.pre   = '0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign cfg_act   = s_q.cfg;
    assign chip_en   = ~rst & (s_q.pre == '0);
    assign data_en   = ~rst & (s_q.dcnt == '0);
    assign restart   = restart_d;
    assign chip_next = ~rst & ~restart_d & (s_d.pre == '0);

    // R2: fast chip rate gives a strobe every cycle
    a_r2_fast_chip: assert property (@(posedge clk) disable iff (rst)
        !is_slow(cfg_act) |-> chip_en);

    // R2: at the divided rate a strobe is never followed by another at once
    a_r2_slow_gap: assert property (@(posedge clk) disable iff (rst)
        (chip_en && is_slow(cfg_act) && !restart) |=> !chip_en);

    // R9: settings only change into a data-strobe cycle
    a_r9_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        !data_en |-> $stable(cfg_act));

endmodule

// File: rtl/ss_chip_seq.sv
module ss_chip_seq
    import ss_timing_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [LEN_W-1:0] len,
    input  logic             advance,
    input  logic             restart,
    output logic [IDX_W-1:0] idx
);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
    } cs_state_t;

    cs_state_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (rst || restart)
            s_d.idx = '0;
        else if (advance)
            s_d.idx = (LEN_W'(s_q.idx) == len - LEN_W'(1)) ? '0 : s_q.idx + IDX_W'(1);
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign idx = s_q.idx;

    // R3: index stays below the active code length
    a_r3_idx_in_range: assert property (@(posedge clk) disable iff (rst)
        LEN_W'(idx) < len);

endmodule

// File: rtl/ss_code_store.sv
module ss_code_store
    import ss_timing_pkg::*;
(
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic             wbit,
    input  logic [IDX_W-1:0] raddr,
    output logic             chip
);

    logic [MAX_LEN-1:0] mem_q, mem_d;

    always_comb begin
        mem_d = mem_q;
        if (we)
            mem_d[waddr] = wbit;
    end

    // Contents survive reset on purpose.
    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign chip = mem_q[raddr];

endmodule

// File: rtl/ss_spreader.sv
module ss_spreader (
    input  logic clk,
    input  logic rst,
    input  logic data_en,
    input  logic data_in,
    input  logic chip,
    output logic mod_out
);

    typedef struct packed {
        logic bit_v;
    } sp_state_t;

    sp_state_t s_q, s_d;
    logic      bit_now;

    always_comb begin
        bit_now = data_en ? data_in : s_q.bit_v;
        s_d     = s_q;
        if (rst)
            s_d.bit_v = 1'b0;
        else if (data_en)
            s_d.bit_v = data_in;
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign mod_out = ~rst & (chip ^ bit_now);

    // R7: between strobes the output only follows the chip
    a_r7_bit_held: assert property (@(posedge clk) disable iff (rst)
        (!data_en && $stable(chip)) |-> $stable(mod_out));

endmodule

// File: rtl/ss_chip_timer.sv
module ss_chip_timer
    import ss_timing_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [LEN_W-1:0] code_len,
    input  logic [DIV_W-1:0] dclk_cfg,
    input  logic             indep_mode,
    input  logic             code_we,
    input  logic [IDX_W-1:0] code_waddr,
    input  logic             code_wbit,
    input  logic             data_in,
    output logic             chip_en,
    output logic             data_en,
    output logic [IDX_W-1:0] chip_idx,
    output logic             mod_out
);

    ss_cfg_t cfg_in;
    ss_cfg_t cfg_act;
    logic    chip_next;
    logic    restart;
    logic    chip_bit;

    always_comb begin
        cfg_in.len   = clamp_len(code_len);
        cfg_in.slow  = dclk_cfg[2];
        cfg_in.ratio = dclk_cfg[1:0];
        cfg_in.div   = dclk_cfg;
        cfg_in.indep = indep_mode;
    end

    ss_rate_gen u_rate (
        .clk       (clk),
        .rst       (rst),
        .cfg_in    (cfg_in),
        .cfg_act   (cfg_act),
        .chip_en   (chip_en),
        .data_en   (data_en),
        .chip_next (chip_next),
        .restart   (restart)
    );

    ss_chip_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .len     (cfg_act.len),
        .advance (chip_next),
        .restart (restart),
        .idx     (chip_idx)
    );

    ss_code_store u_code (
        .clk   (clk),
        .we    (code_we),
        .waddr (code_waddr),
        .wbit  (code_wbit),
        .raddr (chip_idx),
        .chip  (chip_bit)
    );

    ss_spreader u_spread (
        .clk     (clk),
        .rst     (rst),
        .data_en (data_en),
        .data_in (data_in),
        .chip    (chip_bit),
        .mod_out (mod_out)
    );

    // R1: both strobes and index 0 right after reset release
    a_r1_first_strobes: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (chip_en && data_en && chip_idx == '0));

    // R6: locked full-rate mode restarts the code on every bit
    a_r6_code_aligned: assert property (@(posedge clk) disable iff (rst)
        (data_en && !cfg_act.indep && !cfg_act.slow) |-> chip_idx == '0);

    // R6: bit edges never split a chip when the period allows it
    a_r6_chip_boundary: assert property (@(posedge clk) disable iff (rst)
        (data_en && is_slow(cfg_act) && period_of(cfg_act)[1:0] == 2'b00) |-> chip_en);

endmodule

// File: tb/ss_chip_timer_tb.sv
module ss_chip_timer_tb;
    import ss_timing_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [LEN_W-1:0] code_len = '0;
    logic [DIV_W-1:0] dclk_cfg = '0;
    logic             indep_mode = 1'b0;
    logic             code_we = 1'b0;
    logic [IDX_W-1:0] code_waddr = '0;
    logic             code_wbit = 1'b0;
    logic             data_in = 1'b0;
    logic             chip_en, data_en, mod_out;
    logic [IDX_W-1:0] chip_idx;

    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 1'b0;
    bit          code_ref [MAX_LEN];
    logic [31:0] pat = 32'hB4E1_9C27;

    always #4 clk = ~clk;

    ss_chip_timer u_dut (
        .clk        (clk),
        .rst        (rst),
        .code_len   (code_len),
        .dclk_cfg   (dclk_cfg),
        .indep_mode (indep_mode),
        .code_we    (code_we),
        .code_waddr (code_waddr),
        .code_wbit  (code_wbit),
        .data_in    (data_in),
        .chip_en    (chip_en),
        .data_en    (data_en),
        .chip_idx   (chip_idx),
        .mod_out    (mod_out)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input int len, input int dcfg, input bit ind);
        @(negedge clk);
        rst        = 1'b1;
        code_we    = 1'b0;
        code_len   = LEN_W'(len);
        dclk_cfg   = DIV_W'(dcfg);
        indep_mode = ind;
        @(negedge clk);
        #1;
        chk("R1", "chip_en in reset", int'(chip_en), 0);
        chk("R1", "data_en in reset", int'(data_en), 0);
        chk("R1", "mod_out in reset", int'(mod_out), 0);
    endtask

    // One cycle, rel counted from the first cycle after reset or restart.
    task automatic step(input int rel, input int len_e, input bit slow_e,
                        input int per_e, input bit ind, input string idx_tag);
        int idx_e;
        bit b;
        bit den_e;
        bit cen_e;
        @(negedge clk);
        rst     = 1'b0;
        code_we = 1'b0;
        den_e   = (rel % per_e) == 0;
        b       = pat[(rel / per_e) % 32];
        data_in = den_e ? b : ~b;
        cen_e   = slow_e ? ((rel % 4) == 0) : 1'b1;
        idx_e   = (slow_e ? rel / 4 : rel) % len_e;
        #1;
        if (rel == 0)
            chk("R1", "first-cycle strobes", int'(chip_en & data_en), 1);
        chk("R2", "chip_en", int'(chip_en), int'(cen_e));
        chk(ind ? "R5" : "R4", "data_en", int'(data_en), int'(den_e));
        chk(idx_tag, "chip_idx", int'(chip_idx), idx_e);
        chk("R7", "mod_out", int'(mod_out), int'(code_ref[idx_e] ^ b));
        if (den_e && !ind && !slow_e)
            chk("R6", "index at bit edge", int'(chip_idx), 0);
        if (den_e && slow_e && (per_e % 4) == 0)
            chk("R6", "chip at bit edge", int'(chip_en), 1);
    endtask

    task automatic run_cfg(input int len_in, input int dcfg, input bit ind, input int len_e,
                           input bit slow_e, input int per_e, input int ncyc, input string idx_tag);
        do_reset(len_in, dcfg, ind);
        for (int r = 0; r < ncyc; r++)
            step(r, len_e, slow_e, per_e, ind, idx_tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int lens [5] = '{2, 3, 5, 8, 12};
        int divs [6] = '{1, 2, 7, 9, 195, 0};

        // load the code store while held in reset
        for (int i = 0; i < MAX_LEN; i++)
            code_ref[i] = ((i * 37 + 11) % 7) < 3;
        @(negedge clk);
        for (int i = 0; i < MAX_LEN; i++) begin
            code_we    = 1'b1;
            code_waddr = IDX_W'(i);
            code_wbit  = code_ref[i];
            @(negedge clk);
        end
        code_we = 1'b0;

        // locked mode sweep: R2 R3 R4 R6 R7
        for (int li = 0; li < 5; li++)
            for (int s = 0; s < 2; s++)
                for (int n = 0; n < 4; n++) begin
                    int per;
                    per = lens[li] << n;
                    run_cfg(lens[li], (s << 2) | n, 1'b0, lens[li], s[0], per, 2 * per + 8, "R3");
                end

        // free mode sweep, bit 2 of the divisor must not slow the chips: R5 R6
        foreach (divs[k]) begin
            int per;
            per = (divs[k] == 0) ? 256 : divs[k];
            run_cfg(5, divs[k], 1'b1, 5, 1'b0, per, 2 * per + 6, "R6");
        end

        // length clamping: R10
        run_cfg(0, 3, 1'b1, 2, 1'b0, 3, 12, "R10");
        run_cfg(1, 3, 1'b1, 2, 1'b0, 3, 12, "R10");
        run_cfg(100, 3, 1'b1, 64, 1'b0, 3, 140, "R10");

        // R9 free mode: change mid-bit, old bit completes, then restart
        do_reset(5, 7, 1'b1);
        for (int r = 0; r < 3; r++) step(r, 5, 1'b0, 7, 1'b1, "R9");
        dclk_cfg = 8'd4;
        for (int r = 3; r < 7; r++) step(r, 5, 1'b0, 7, 1'b1, "R9");
        for (int r = 0; r < 12; r++) begin
            step(r, 5, 1'b0, 4, 1'b1, "R9");
            if (r == 0)
                chk("R9", "restart index after swap", int'(chip_idx), 0);
        end

        // R9 locked mode: length 6 with exponent 1, then length 5 with exponent 0
        do_reset(6, 1, 1'b0);
        for (int r = 0; r < 4; r++) step(r, 6, 1'b0, 12, 1'b0, "R9");
        code_len = 7'd5;
        dclk_cfg = 8'd0;
        for (int r = 4; r < 12; r++) step(r, 6, 1'b0, 12, 1'b0, "R9");
        for (int r = 0; r < 15; r++) begin
            step(r, 5, 1'b0, 5, 1'b0, "R9");
            if (r == 0)
                chk("R9", "strobes after swap", int'(chip_en & data_en), 1);
        end

        // R8: rewrite the chip about to be shown
        do_reset(4, 3, 1'b1);
        for (int r = 0; r < 6; r++) step(r, 4, 1'b0, 3, 1'b1, "R3");
        code_we     = 1'b1;
        code_waddr  = 6'd2;
        code_wbit   = ~code_ref[2];
        code_ref[2] = ~code_ref[2];
        step(6, 4, 1'b0, 3, 1'b1, "R3");
        chk("R8", "written chip at output", int'(mod_out),
            int'(code_ref[2] ^ pat[2]));
        for (int r = 7; r < 12; r++) step(r, 4, 1'b0, 3, 1'b1, "R3");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule